// File: doc/BRIEF.md
# Three-Wire LSB-First Serial Master

This block is a half-duplex serial master for one slave device on a single shared data wire. A real-time clock chip is a typical slave. The host raises a select request to assert the slave's active-high chip select. It then starts one byte at a time and chooses, per byte, whether that byte is sent or received. The master drives SCLK, which idles low, and sends or collects bits least significant first. When the eighth bit is complete it gives a one-cycle done strobe. The chip select stays asserted between bytes until the host drops the select request. This lets a command byte and its data bytes share one selection.

A divider input sets the SCLK half-period in system clocks; the value is captured when a byte starts. Outgoing data changes only while SCLK is low and is stable across each rising edge. The slave shifts read data on falling edges, and the master samples it at the end of each low phase, just before the next rising edge. The pad is split into an output value, an output enable and an input. Enable high means the master drives the wire; enable low means the pad floats so the slave can drive it.

Top module: `uwire3_master`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, sclk, cs, sd_oe, busy and done are all 0.
- R2: While idle, cs follows sel_req with one cycle of delay. During a byte cs is 1, and after a byte cs stays 1 for as long as sel_req remains 1.
- R3: In a send byte (dir_rx = 0), the value of sd_out at the n-th rising SCLK edge is tx_byte[n-1], for n = 1..8; bit 0 goes first.
- R4: sd_out never changes while sclk stays high.
- R5: In a receive byte (dir_rx = 1), the sd_in value sampled at the end of the n-th low phase becomes rx_byte[n-1]. rx_byte is valid in the cycle done is 1.
- R6: sd_oe is 1 for the whole of a send byte and 0 for the whole of a receive byte. It is 0 whenever the block is idle.
- R7: Each SCLK low and high phase lasts div+1 clock cycles. done rises exactly 16*(div+1) clock edges after the edge that accepted start.
- R8: done is a single-cycle pulse. A send byte leaves rx_byte unchanged.
- R9: cs is 1 for at least div+1 clock cycles before the first rising SCLK edge of a byte.
- R10: start is ignored while busy is 1, and also when sel_req is 0. An ignored start begins no byte and changes no bus output.
- R11: sclk is 0 whenever busy is 0. Changing div or dir_rx during a byte does not alter the byte in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div | input | DIV_W (8) | SCLK half-period minus one, in clk cycles; captured at start |
| sel_req | input | 1 | Host request to assert chip select |
| start | input | 1 | Begin one byte; honoured only when idle with sel_req high |
| dir_rx | input | 1 | 1 = receive byte, 0 = send byte; captured at start |
| tx_byte | input | W (8) | Byte to send; captured at start |
| sclk | output | 1 | Serial clock, idles low |
| cs | output | 1 | Active-high chip select |
| sd_out | output | 1 | Data value for the shared pad |
| sd_oe | output | 1 | Pad drive enable (0 = pad floats) |
| sd_in | input | 1 | Value read from the shared pad |
| busy | output | 1 | A byte is in progress |
| done | output | 1 | One-cycle strobe when a byte completes |
| rx_byte | output | W (8) | Last received byte |

## Verification
The hardest situation to reach is a start that arrives while a byte is already running, together with new div and dir_rx values. From the ports, this looks exactly like the start of a second byte. To reach it, the bench pulses start mid-byte with a flipped direction and a new divider. It then confirms three things: the running byte keeps its original timing, direction and data; no second byte follows; and the shift order matches on both the send and receive paths. A behavioural slave drives sd_in after each falling edge and captures sd_out at each rising edge. Byte values are chosen so that a reversed bit order gives a different value.

// File: rtl/uwire3_master.sv
module uwire3_master #(
  parameter int DIV_W = 8,
  parameter int W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             sel_req,
  input  logic             start,
  input  logic             dir_rx,
  input  logic [W-1:0]     tx_byte,
  output logic             sclk,
  output logic             cs,
  output logic             sd_out,
  output logic             sd_oe,
  input  logic             sd_in,
  output logic             busy,
  output logic             done,
  output logic [W-1:0]     rx_byte
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_t;

  phase_t           ph;
  logic [DIV_W-1:0] cnt, div_q;
  logic [CW-1:0]    bitn;
  logic             dir_q, cs_q, done_q;
  logic [W-1:0]     txsh, rxsh, rx_q;

  wire half_end = (cnt == div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      div_q  <= '0;
      bitn   <= '0;
      dir_q  <= 1'b0;
      cs_q   <= 1'b0;
      done_q <= 1'b0;
      txsh   <= '0;
      rxsh   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (ph)
        PH_IDLE: begin
          cs_q <= sel_req;
          if (start && sel_req) begin
            ph    <= PH_LOW;
            cnt   <= '0;
            bitn  <= '0;
            dir_q <= dir_rx;
            div_q <= div;
            txsh  <= tx_byte;
          end
        end
        PH_LOW: begin
          if (half_end) begin
            cnt <= '0;
            ph  <= PH_HIGH;
            if (dir_q) rxsh <= {sd_in, rxsh[W-1:1]};
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_HIGH: begin
          if (half_end) begin
            cnt <= '0;
            if (bitn == LAST) begin
              ph     <= PH_IDLE;
              done_q <= 1'b1;
              if (dir_q) rx_q <= rxsh;
            end else begin
              ph   <= PH_LOW;
              bitn <= bitn + 1'b1;
              txsh <= {1'b0, txsh[W-1:1]};
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign busy    = (ph != PH_IDLE);
  assign sclk    = (ph == PH_HIGH);
  assign cs      = cs_q;
  assign sd_out  = txsh[0];
  assign sd_oe   = busy && !dir_q;
  assign done    = done_q;
  assign rx_byte = rx_q;
endmodule

// File: rtl/uwire3_master_chk.sv
module uwire3_master_chk (
  input logic clk,
  input logic rst_n,
  input logic sel_req,
  input logic start,
  input logic sclk,
  input logic cs,
  input logic sd_out,
  input logic sd_oe,
  input logic busy,
  input logic done
);
  // R4
  sd_out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sd_out));
  // R2
  cs_under_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> cs);
  // R6
  oe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe |-> (cs && busy));
  // R11
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start && sel_req));
  // R9
  lead_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $past(cs));
endmodule

bind uwire3_master uwire3_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sel_req(sel_req), .start(start), .sclk(sclk),
  .cs(cs), .sd_out(sd_out), .sd_oe(sd_oe), .busy(busy), .done(done)
);

// File: tb/tb_uwire3_master.sv
module tb_uwire3_master;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] div = 8'd0, tx_byte = 8'd0;
  logic       sel_req = 1'b0, start = 1'b0, dir_rx = 1'b0, sd_in = 1'b0;
  logic       sclk, cs, sd_out, sd_oe, busy, done;
  logic [7:0] rx_byte;

  uwire3_master dut (
    .clk(clk), .rst_n(rst_n), .div(div), .sel_req(sel_req), .start(start),
    .dir_rx(dir_rx), .tx_byte(tx_byte), .sclk(sclk), .cs(cs), .sd_out(sd_out),
    .sd_oe(sd_oe), .sd_in(sd_in), .busy(busy), .done(done), .rx_byte(rx_byte)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int rises = 0, oebad = 0, sidx = 0;
  logic [7:0] cap = 8'd0, slave_byte = 8'd0;
  logic       cur_dir = 1'b0;

  // {dir_rx, div, data}
  localparam logic [16:0] VEC [0:5] = '{
    {1'b0, 8'd1, 8'hC1}, {1'b1, 8'd0, 8'h1E}, {1'b0, 8'd0, 8'h01},
    {1'b1, 8'd2, 8'h80}, {1'b0, 8'd3, 8'hF0}, {1'b1, 8'd1, 8'h6D}
  };

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(posedge sclk) begin
    cap = {sd_out, cap[7:1]};
    rises++;
    if (sd_oe !== !cur_dir || cs !== 1'b1) oebad++;
  end

  always @(negedge sclk) begin
    sidx++;
    sd_in = (sidx < 8) ? slave_byte[sidx] : 1'b0;
  end

  int tbad, cyc, lead_ok;

  task automatic run_byte(input logic d, input logic [7:0] dv, input logic [7:0] data,
                          input int poke_at, input logic [7:0] pdv);
    int total, h;
    logic [7:0] prev_rx;
    total = 16 * (int'(dv) + 1);
    h = int'(dv) + 1;
    prev_rx = rx_byte;
    @(negedge clk);
    div = dv; dir_rx = d; tx_byte = data; slave_byte = data;
    cur_dir = d; sidx = 0; sd_in = data[0]; rises = 0; oebad = 0; cap = 8'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0; tbad = 0; lead_ok = 1;
    while (!done && cyc < 5000) begin
      if (cyc < total) begin
        if (sclk !== (((cyc / h) % 2) == 1)) tbad++;
        if (cs !== 1'b1) tbad++;
      end
      if (cyc == poke_at) begin
        start = 1'b1; div = pdv; dir_rx = !d; tx_byte = ~data;
      end else begin
        start = 1'b0;
      end
      if (cyc == h - 1 && (sclk !== 1'b0 || cs !== 1'b1)) lead_ok = 0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    // R7
    chk(cyc == total, "R7 done latency", cyc, total);
    chk(tbad == 0, "R7/R11 sclk phase timing", tbad, 0);
    // R9
    chk(lead_ok == 1, "R9 cs lead before first rise", lead_ok, 1);
    // R6
    chk(oebad == 0 && rises == 8, "R6 pad enable per byte", oebad, 0);
    if (!d) begin
      // R3
      chk(cap == data, "R3 lsb-first send", cap, data);
      // R8
      chk(rx_byte == prev_rx, "R8 send leaves rx_byte", rx_byte, prev_rx);
    end else begin
      // R5
      chk(rx_byte == data, "R5 lsb-first receive", rx_byte, data);
    end
    @(negedge clk);
    // R8
    chk(done == 1'b0 && busy == 1'b0, "R8 single done pulse, no extra byte", {done, busy}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk({sclk, cs, sd_oe, busy, done} == 5'b0, "R1 reset state", {sclk, cs, sd_oe, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({sclk, cs, sd_oe, busy, done} == 5'b0, "R1 after release", {sclk, cs, sd_oe, busy, done}, 0);

    // R10: start with sel_req low is ignored
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk({busy, cs, sclk, sd_oe} == 4'b0, "R10 start without select", {busy, cs, sclk, sd_oe}, 0);

    // R2: cs follows sel_req while idle
    sel_req = 1'b1;
    @(negedge clk);
    chk(cs == 1'b1 && sclk == 1'b0, "R2 cs follows request", cs, 1);

    foreach (VEC[i]) begin
      run_byte(VEC[i][16], VEC[i][15:8], VEC[i][7:0], -1, 8'd0);
      // R2
      chk(cs == 1'b1, "R2 cs held between bytes", cs, 1);
    end

    // R10/R11: start, new div and dir during a byte are ignored
    run_byte(1'b0, 8'd2, 8'h37, 20, 8'd0);
    run_byte(1'b1, 8'd1, 8'hB4, 9, 8'd5);

    // R2: release
    sel_req = 1'b0;
    @(negedge clk);
    chk(cs == 1'b0, "R2 cs released", cs, 0);
    repeat (3) @(negedge clk);
    chk({busy, sclk, sd_oe} == 3'b0, "R11 idle bus", {busy, sclk, sd_oe}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule